// File: doc/BRIEF.md
# JTAG Serial Character Channel Buffer

This block carries a byte-wide, UART-like character stream between a debug host and on-chip logic, using the data-register scans of a JTAG test access port. Two byte queues sit inside it: one holds characters sent by the host and bound for the target, and the other holds characters produced by the target and waiting for the host. Every data-register scan moves one fixed 72-bit frame in each direction. The frame starts with an 8-bit header and carries eight data byte lanes after it. The header travels both ways in the same scan, so each exchange carries its own flow control and no separate status scan is needed.

The TAP controller drives one-cycle strobes on the block clock. A capture strobe takes a snapshot of the queue levels and of the oldest target bytes. Shift strobes move one bit in and one bit out per cycle, least significant bit first. An update strobe commits the exchange. On the target side there are two valid/ready byte streams. Toward the target, `h2t_valid` stays high while host bytes are queued, and the head byte and valid hold until `h2t_ready` takes them. From the target, a byte is taken on any cycle where `t2h_valid` and `t2h_ready` are both high. `t2h_ready` drops while the target-bound queue is full, and the target must then hold its byte.

Top module: `jsp_buffer`

## Requirements
- R1: After reset both queues are empty, `h2t_valid` is 0 and `t2h_ready` is 1. The first header read back is 0x08 with the default depth of 16.
- R2: A frame is 72 bits, shifted least significant bit first. Bits 0..7 are the header, and data lane k occupies bits 8+8k to 15+8k. On the way in, header bits 7:4 give the number of host bytes offered.
- R3: The outgoing header is sampled at the capture strobe. Bits 7:4 give the number of target bytes waiting for the host, and bits 3:0 give the free slots in the host-to-target queue.
- R4: Outgoing lanes carry the waiting target bytes oldest first, up to the count reported. Lanes beyond that count read 0, and `tdo` is 0 once 72 bits have been shifted.
- R5: An update after at least 72 shifted bits removes exactly the reported number of target bytes from the host-bound queue.
- R6: That update queues the first min(offered count, reported free count) host lanes, in lane order. Further lanes are dropped, and offered counts from 9 to 15 act as 8.
- R7: An update after fewer than 72 shifted bits changes neither queue.
- R8: A 73rd bit, such as the 0 the host appends, is ignored, and the exchange commits as a normal 72-bit frame.
- R9: `h2t_valid` is high while host bytes are queued. `h2t_data` gives them in arrival order, and both hold while `h2t_ready` is low.
- R10: `t2h_ready` is low while the host-bound queue holds DEPTH bytes. A byte offered then is not stored.
- R11: Both header counts saturate at 8 when a queue holds or frees more than 8 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_dr | input | 1 | One-cycle strobe: snapshot counts and outgoing frame |
| shift_dr | input | 1 | Move one frame bit per cycle |
| update_dr | input | 1 | One-cycle strobe: commit the exchange |
| tdi | input | 1 | Serial bit from the host |
| tdo | output | 1 | Serial bit to the host |
| h2t_valid | output | 1 | Host byte available for the target |
| h2t_ready | input | 1 | Target takes the host byte |
| h2t_data | output | 8 | Oldest queued host byte |
| t2h_valid | input | 1 | Target offers a byte |
| t2h_ready | output | 1 | Host-bound queue has room |
| t2h_data | input | 8 | Byte offered by the target |

## Verification
Some properties hold on every cycle, and the assertions check those. The target stream holds its byte under back-pressure. Neither queue exceeds its depth. `tdo` is quiet past bit 72. The host-bound level falls only on an update, and it never falls after a short scan. Other behaviour only shows across a whole exchange, so the bench's scenarios cover it. These are the header values, including saturation and the free count limiting writes, and the lane order and zero fill. They also include the tolerance of a 73rd bit, rejection of a byte offered while full, and the arrival order of host bytes at the target.

// File: rtl/jsp_pkg.sv
package jsp_pkg;
  localparam int unsigned LANES      = 8;
  localparam int unsigned NIB_W      = 4;
  localparam int unsigned HDR_BITS   = 8;
  localparam int unsigned FRAME_BITS = HDR_BITS + LANES * 8;
  localparam int unsigned POS_W      = $clog2(FRAME_BITS + 1);

  // clamp a level to what a header nibble may report
  function automatic logic [NIB_W-1:0] sat_lanes(input logic [31:0] v);
    if (v > 32'(LANES)) return NIB_W'(LANES);
    return v[NIB_W-1:0];
  endfunction
endpackage

// File: rtl/jsp_fifo.sv
// Byte queue that accepts NW bytes and retires NR bytes per cycle,
// with the NR oldest entries visible. DEPTH must be a power of two >= 2.
module jsp_fifo #(
  parameter int DEPTH = 16,
  parameter int NW    = 1,
  parameter int NR    = 1,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int WNW  = $clog2(NW + 1),
  localparam int RNW  = $clog2(NR + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WNW-1:0]  wr_n,
  input  logic [NW*8-1:0] wr_data,
  input  logic [RNW-1:0]  rd_n,
  output logic [NR*8-1:0] rd_data,
  output logic [CW-1:0]   count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr + AW'(wr_n);
      rptr  <= rptr + AW'(rd_n);
      count <= count + CW'(wr_n) - CW'(rd_n);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NW; i++) begin
      if (WNW'(i) < wr_n) mem[wptr + AW'(i)] <= wr_data[8*i +: 8];
    end
  end

  for (genvar g = 0; g < NR; g++) begin : g_peek
    assign rd_data[8*g +: 8] = mem[rptr + AW'(g)];
  end
endmodule

// File: rtl/jsp_frame.sv
// Frame engine: snapshot at capture, serial exchange, commit at update.
module jsp_frame
  import jsp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 capture,
  input  logic                 shift,
  input  logic                 update,
  input  logic                 tdi,
  output logic                 tdo,
  input  logic [NIB_W-1:0]     avail,
  input  logic [NIB_W-1:0]     free,
  input  logic [LANES*8-1:0]   peek,
  output logic [NIB_W-1:0]     wr_n,
  output logic [LANES*8-1:0]   wr_bytes,
  output logic [NIB_W-1:0]     rd_n
);
  logic [FRAME_BITS-1:0]       out_q, snap;
  logic [FRAME_BITS-1:NIB_W]   in_q;
  logic [POS_W-1:0]            pos;
  logic [NIB_W-1:0]            avail_q, free_q, req, grant;
  logic                        in_frame, commit;

  always_comb begin
    snap = '0;
    snap[HDR_BITS-1:NIB_W] = avail;
    snap[NIB_W-1:0]        = free;
    for (int k = 0; k < LANES; k++) begin
      if (NIB_W'(k) < avail) snap[HDR_BITS + 8*k +: 8] = peek[8*k +: 8];
    end
  end

  assign in_frame = pos < POS_W'(FRAME_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      in_q    <= '0;
      pos     <= '0;
      avail_q <= '0;
      free_q  <= '0;
    end else if (capture) begin
      out_q   <= snap;
      avail_q <= avail;
      free_q  <= free;
      pos     <= '0;
    end else if (shift && in_frame) begin
      if (pos >= POS_W'(NIB_W)) in_q[pos] <= tdi;
      pos <= pos + 1'b1;
    end else if (update) begin
      pos <= '0;
    end
  end

  assign tdo      = in_frame ? out_q[pos] : 1'b0;
  assign commit   = update && !in_frame;
  assign req      = in_q[HDR_BITS-1:NIB_W];
  assign grant    = (req < free_q) ? req : free_q;
  assign wr_n     = commit ? grant : '0;
  assign rd_n     = commit ? avail_q : '0;
  assign wr_bytes = in_q[FRAME_BITS-1:HDR_BITS];
endmodule

// File: rtl/jsp_buffer.sv
module jsp_buffer
  import jsp_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture_dr,
  input  logic       shift_dr,
  input  logic       update_dr,
  input  logic       tdi,
  output logic       tdo,
  output logic       h2t_valid,
  input  logic       h2t_ready,
  output logic [7:0] h2t_data,
  input  logic       t2h_valid,
  output logic       t2h_ready,
  input  logic [7:0] t2h_data
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]        tx_count, rx_count;
  logic [NIB_W-1:0]     avail, free, host_wr_n, host_rd_n;
  logic [LANES*8-1:0]   host_bytes, rx_peek;
  logic                 tx_pop, rx_push;

  assign avail = sat_lanes(32'(rx_count));
  assign free  = sat_lanes(32'(CW'(DEPTH) - tx_count));

  jsp_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture_dr),
    .shift    (shift_dr),
    .update   (update_dr),
    .tdi      (tdi),
    .tdo      (tdo),
    .avail    (avail),
    .free     (free),
    .peek     (rx_peek),
    .wr_n     (host_wr_n),
    .wr_bytes (host_bytes),
    .rd_n     (host_rd_n)
  );

  // host -> target
  assign h2t_valid = tx_count != '0;
  assign tx_pop    = h2t_valid && h2t_ready;

  jsp_fifo #(.DEPTH(DEPTH), .NW(LANES), .NR(1)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_n    (host_wr_n),
    .wr_data (host_bytes),
    .rd_n    (tx_pop),
    .rd_data (h2t_data),
    .count   (tx_count)
  );

  // target -> host
  assign t2h_ready = rx_count != CW'(DEPTH);
  assign rx_push   = t2h_valid && t2h_ready;

  jsp_fifo #(.DEPTH(DEPTH), .NW(1), .NR(LANES)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_n    (rx_push),
    .wr_data (t2h_data),
    .rd_n    (host_rd_n),
    .rd_data (rx_peek),
    .count   (rx_count)
  );
endmodule

// File: rtl/jsp_buffer_chk.sv
module jsp_buffer_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          capture_dr,
  input logic          shift_dr,
  input logic          update_dr,
  input logic          tdo,
  input logic          h2t_valid,
  input logic          h2t_ready,
  input logic [7:0]    h2t_data,
  input logic          t2h_valid,
  input logic          t2h_ready,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count
);
  logic [6:0] sh_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           sh_cnt <= '0;
    else if (capture_dr)                  sh_cnt <= '0;
    else if (shift_dr && sh_cnt < 7'd72)  sh_cnt <= sh_cnt + 7'd1;
    else if (update_dr)                   sh_cnt <= '0;
  end

  // R9
  a_r9_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (h2t_valid && !h2t_ready) |=> (h2t_valid && $stable(h2t_data)));

  // R10
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

  // R4
  a_r4_tdo_quiet_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_cnt == 7'd72) |-> !tdo);

  // R7
  a_r7_short_scan_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (update_dr && sh_cnt < 7'd72 && !(t2h_valid && t2h_ready)) |=> (rx_count == $past(rx_count)));

  // R5
  a_r5_pop_only_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    !update_dr |=> (rx_count >= $past(rx_count)));
endmodule

bind jsp_buffer jsp_buffer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .capture_dr (capture_dr),
  .shift_dr   (shift_dr),
  .update_dr  (update_dr),
  .tdo        (tdo),
  .h2t_valid  (h2t_valid),
  .h2t_ready  (h2t_ready),
  .h2t_data   (h2t_data),
  .t2h_valid  (t2h_valid),
  .t2h_ready  (t2h_ready),
  .tx_count   (tx_count),
  .rx_count   (rx_count)
);

// File: tb/jsp_buffer_tb.sv
module jsp_buffer_tb;
  localparam int DEPTH = 16;

  typedef struct packed {
    logic [4:0] tpush;
    logic [3:0] wc;
    logic [6:0] nbits;
    logic       drain;
    logic [7:0] hdr;
  } row_t;

  // target bytes pushed, offered count, scan length, drain after, expected header
  localparam row_t ROWS [10] = '{
    '{5'd0,  4'd3,  7'd72, 1'b1, 8'h08},  // R1 R6
    '{5'd5,  4'd0,  7'd72, 1'b1, 8'h58},  // R3 R4 R5
    '{5'd12, 4'd8,  7'd72, 1'b0, 8'h88},  // R11
    '{5'd0,  4'd5,  7'd72, 1'b0, 8'h48},
    '{5'd0,  4'd5,  7'd72, 1'b1, 8'h03},  // R6 free limit
    '{5'd2,  4'd4,  7'd50, 1'b1, 8'h28},  // R7 short
    '{5'd0,  4'd15, 7'd73, 1'b1, 8'h28},  // R8 R6
    '{5'd16, 4'd0,  7'd72, 1'b0, 8'h88},  // R10
    '{5'd0,  4'd0,  7'd72, 1'b0, 8'h88},
    '{5'd0,  4'd0,  7'd72, 1'b0, 8'h08}
  };

  logic clk = 0, rst_n = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic tdo, h2t_valid, h2t_ready = 0, t2h_valid = 0, t2h_ready;
  logic [7:0] h2t_data, t2h_data = 0;

  int checks = 0, fails = 0;
  logic [7:0] rq[$], hq[$];
  logic [7:0] tseq = 8'hA0;

  always #2 clk = ~clk;

  jsp_buffer #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .h2t_valid(h2t_valid),
    .h2t_ready(h2t_ready), .h2t_data(h2t_data), .t2h_valid(t2h_valid),
    .t2h_ready(t2h_ready), .t2h_data(t2h_data)
  );

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic scan(input logic [3:0] wc, input logic [63:0] dat, input int nbits,
                      output logic [72:0] got);
    logic [72:0] fin;
    fin = {1'b0, dat, wc, 4'b0000};
    got = '0;
    @(negedge clk) capture_dr = 1;
    @(posedge clk);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      capture_dr = 0;
      got[i] = tdo;
      tdi = fin[i];
      shift_dr = 1;
      @(posedge clk);
    end
    @(negedge clk);
    shift_dr = 0;
    update_dr = 1;
    @(posedge clk);
    @(negedge clk) update_dr = 0;
  endtask

  task automatic push_target(input logic [7:0] v);
    @(negedge clk);
    t2h_valid = 1;
    t2h_data = v;
    @(posedge clk);
    @(negedge clk) t2h_valid = 0;
  endtask

  task automatic drain(input string req);
    forever begin
      @(negedge clk);
      if (!h2t_valid) break;
      if (hq.size() == 0) begin
        check(req, 72'(h2t_valid), 72'd0);
        break;
      end
      check(req, 72'(h2t_data), 72'(hq.pop_front()));
      h2t_ready = 1;
      @(posedge clk);
    end
    h2t_ready = 0;
    check(req, 72'(hq.size()), 72'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements) act=timeout exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [72:0] got;
    logic [63:0] dat;
    logic [7:0]  hold_b;
    int av, fr, n;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check("R1 h2t_valid after reset", 72'(h2t_valid), 72'd0);
    check("R1 t2h_ready after reset", 72'(t2h_ready), 72'd1);

    for (int r = 0; r < 10; r++) begin
      for (int j = 0; j < int'(ROWS[r].tpush); j++) begin
        push_target(tseq);
        rq.push_back(tseq);
        tseq = tseq + 8'd1;
      end
      if (rq.size() == DEPTH) begin
        // R10: offered byte while full must not be stored
        @(negedge clk);
        check("R10 ready low when full", 72'(t2h_ready), 72'd0);
        t2h_valid = 1;
        t2h_data = 8'hEE;
        @(posedge clk);
        @(negedge clk) t2h_valid = 0;
      end
      av = (rq.size() > 8) ? 8 : rq.size();
      fr = (DEPTH - hq.size() > 8) ? 8 : DEPTH - hq.size();
      for (int i = 0; i < 8; i++) dat[8*i +: 8] = 8'(r * 16 + i + 1);
      scan(ROWS[r].wc, dat, int'(ROWS[r].nbits), got);
      check("R3 R11 header", 72'(got[7:0]), 72'(ROWS[r].hdr));
      if (ROWS[r].nbits >= 7'd72) begin
        for (int k = 0; k < 8; k++)
          check("R2 R4 lane", 72'(got[8 + 8*k +: 8]), 72'((k < av) ? rq[k] : 8'h00));
        if (ROWS[r].nbits == 7'd73) check("R8 R4 tdo past frame", 72'(got[72]), 72'd0);
        for (int k = 0; k < av; k++) void'(rq.pop_front());
        n = (int'(ROWS[r].wc) < fr) ? int'(ROWS[r].wc) : fr;
        for (int i = 0; i < n; i++) hq.push_back(dat[8*i +: 8]);
      end else begin
        @(negedge clk);
        check("R7 no host write on short scan", 72'(h2t_valid), 72'(hq.size() != 0));
      end
      if (ROWS[r].drain) begin
        drain("R9 R6 host byte order");
      end else if (hq.size() != 0) begin
        @(negedge clk);
        hold_b = h2t_data;
        repeat (3) @(negedge clk);
        check("R9 valid held", 72'(h2t_valid), 72'd1);
        check("R9 data held", 72'(h2t_data), 72'(hold_b));
        check("R9 oldest first", 72'(h2t_data), 72'(hq[0]));
      end
    end

    // R5: nothing left after the last row
    scan(4'd0, 64'd0, 72, got);
    check("R5 host queue drained", 72'(got[7:0]), 72'h08);

    // R1: reset in the middle of traffic clears both queues
    for (int j = 0; j < 3; j++) push_target(8'h30 + 8'(j));
    scan(4'd2, 64'h0000_0000_0000_5A5A, 72, got);
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    rq.delete();
    hq.delete();
    @(negedge clk);
    check("R1 h2t_valid after mid reset", 72'(h2t_valid), 72'd0);
    check("R1 t2h_ready after mid reset", 72'(t2h_ready), 72'd1);
    scan(4'd0, 64'd0, 72, got);
    check("R1 header after mid reset", 72'(got[7:0]), 72'h08);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule